// File: doc/BRIEF.md
# Error Report Header Sequencer

This block sits between application logic and a transaction-layer core that takes completion-error reports. Each request carries a six-bit error-type vector, a three-bit function number, a flag that asks for header logging, and a 128-bit header. A logged request first sends the header to the core's local management port as four 32-bit register writes. Each write is a one-cycle strobe, and the next write waits for the port to acknowledge the previous one. Only after the fourth acknowledge does the block pulse the seven-bit error vector, with the log bit set, together with the function number.

The core synchronises the error strobes into another clock domain, so pulses must be at least eight cycles apart. A request without logging skips the register writes but still obeys that spacing. One request can wait in a single-entry holding slot while the previous one is still writing or still inside its spacing window. The ready output is low whenever that slot is occupied.

Top module: `errhdr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge (synchronous, active low), the block returns to idle and empties its slot. Afterwards `err_vec`, `err_func` and `mgmt_wr` read zero and `req_ready` reads one.
- R2: A request is taken at an edge where `req_valid` and `req_ready` are both high. `req_ready` is low exactly while the single holding slot is occupied, and `req_valid` has no effect while `req_ready` is low.
- R3: A logged request issues exactly four one-cycle `mgmt_wr` strobes, at addresses 0x81C, 0x820, 0x824 and 0x828 in that order.
- R4: The write to 0x81C carries header bits 127:96, 0x820 bits 95:64, 0x824 bits 63:32 and 0x828 bits 31:0.
- R5: After a strobe the block holds until `mgmt_ack` is seen in a later cycle, and the next strobe follows in the cycle after that acknowledge. `mgmt_ack` has no effect at any other time.
- R6: Bit 6 of `err_vec` (the log bit) is high in the pulse of every logged request, and only in the cycle after the fourth write has been acknowledged.
- R7: A pulse lasts one cycle. Bits 5:0 of `err_vec` equal the request's error bits and `err_func` equals its function number in that same cycle. Both are zero in every other cycle.
- R8: Two cycles that carry a nonzero `err_vec` are at least 8 cycles apart.
- R9: A request without logging causes no `mgmt_wr`. Accepted into an idle block outside any spacing window, it pulses two cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Holding slot empty, request will be taken |
| req_kind | input | 6 | Error-type bits, placed on err_vec[5:0] |
| req_log | input | 1 | Header logging requested |
| req_func | input | 3 | Function number of the request |
| req_hdr | input | 128 | Header to log, bits 127:96 written first |
| mgmt_wr | output | 1 | One-cycle management write strobe |
| mgmt_addr | output | 12 | Management register address |
| mgmt_data | output | 32 | Management write data |
| mgmt_ack | input | 1 | Management write accepted |
| err_vec | output | 7 | Error strobe vector, bit 6 is the log bit |
| err_func | output | 3 | Function number paired with err_vec |

## Verification
A wrong phase or word index shows at the management port within one cycle as a missing, doubled or misaddressed strobe. It also shows as data taken from the wrong quarter of the header. A spacing counter loaded with the wrong value moves the next queued pulse off its expected cycle by that error. A slot flag that is set or cleared wrongly shows straight away as a `req_ready` mismatch. It also shows, a few cycles later, as a lost or repeated pulse. The bench compares every output against a behavioural model on every cycle, so each of these is reported in the cycle where it first appears.

// File: rtl/errhdr_pkg.sv
// Shared widths, request record, sequencer phases and the header word picker.
// Assumes the header is a whole number of 32-bit words, sent most significant first.
package errhdr_pkg;
    localparam int KIND_W    = 6;
    localparam int FUNC_W    = 3;
    localparam int WORD_W    = 32;
    localparam int HDR_WORDS = 4;
    localparam int HDR_W     = WORD_W * HDR_WORDS;
    localparam int IDX_W     = $clog2(HDR_WORDS);

    typedef struct packed {
        logic              log_hdr;
        logic [FUNC_W-1:0] func;
        logic [KIND_W-1:0] kind;
        logic [HDR_W-1:0]  hdr;
    } err_req_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_WAIT  = 2'd2,
        PH_FIRE  = 2'd3
    } seq_ph_e;

    // Word idx of the header, where word 0 is the most significant one.
    function automatic logic [WORD_W-1:0] hdr_word(input logic [HDR_W-1:0] hdr,
                                                   input logic [IDX_W-1:0] idx);
        return hdr[HDR_W - 1 - int'(idx) * WORD_W -: WORD_W];
    endfunction
endpackage

// File: rtl/errhdr_slot.sv
// Single-entry holding slot for error requests.
// Assumes pop is asserted only while the slot is full. Data is not reset; only the flag is.
module errhdr_slot
    import errhdr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_valid,
    input  err_req_t push_req,
    output logic     push_ready,
    input  logic     pop,
    output logic     full,
    output err_req_t held_req
);
    logic     full_q;
    err_req_t req_q;

    assign push_ready = !full_q;
    assign full       = full_q;
    assign held_req   = req_q;

    // Occupancy flag: set on an accepted push, cleared on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)                       full_q <= 1'b0;
        else if (push_valid && !full_q)   full_q <= 1'b1;
        else if (pop)                     full_q <= 1'b0;
    end

    // Request storage: captured only when a push is taken.
    always_ff @(posedge clk) begin
        if (push_valid && !full_q) req_q <= push_req;
    end

    // R2
    slot_pop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> full_q);
    // R2
    slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !pop) |=> full_q);
endmodule

// File: rtl/errhdr_gap.sv
// Holdoff counter that spaces error pulses at least GAP cycles apart.
// Assumes GAP >= 2. The counter is loaded in the pulse cycle, and the window opens in
// time for a request loaded in its last cycle to pulse exactly GAP cycles later.
module errhdr_gap #(
    parameter int GAP = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic open
);
    localparam int CNT_W = (GAP > 2) ? $clog2(GAP) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GAP - 2);

    logic [CNT_W-1:0] cnt_q;

    assign open = (cnt_q == '0);

    // Countdown: reload on a pulse, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (fire)           cnt_q <= RELOAD;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // R8
    gap_fire_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(open));
endmodule

// File: rtl/errhdr_fsm.sv
// Sequencer: takes a request from the slot, writes its header word by word through the
// management port if logging is asked for, then drives a one-cycle error pulse.
// Assumes mgmt_ack is only meaningful in the cycles after a strobe (WAIT phase).
module errhdr_fsm
    import errhdr_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] HDR_BASE = 12'h81C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              have_req,
    input  logic              gap_open,
    input  err_req_t          req,
    input  logic              mgmt_ack,
    output logic              pop,
    output logic              mgmt_wr,
    output logic [ADDR_W-1:0] mgmt_addr,
    output logic [WORD_W-1:0] mgmt_data,
    output logic [KIND_W:0]   err_vec,
    output logic [FUNC_W-1:0] err_func,
    output logic              fire
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_WORDS - 1);

    seq_ph_e          ph_q;
    logic [IDX_W-1:0] idx_q;
    err_req_t         cur_q;

    assign pop = (ph_q == PH_IDLE) && have_req && gap_open;

    // Phase and word index progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            idx_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: if (pop) begin
                    ph_q  <= req.log_hdr ? PH_WRITE : PH_FIRE;
                    idx_q <= '0;
                end
                PH_WRITE: ph_q <= PH_WAIT;
                PH_WAIT: if (mgmt_ack) begin
                    if (idx_q == LAST_IDX) ph_q <= PH_FIRE;
                    else begin
                        idx_q <= idx_q + 1'b1;
                        ph_q  <= PH_WRITE;
                    end
                end
                PH_FIRE: ph_q <= PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Current request capture on pop.
    always_ff @(posedge clk) begin
        if (pop) cur_q <= req;
    end

    // Management write outputs: strobe in WRITE, address and data follow the index.
    always_comb begin
        mgmt_wr   = (ph_q == PH_WRITE);
        mgmt_addr = HDR_BASE + {{(ADDR_W-IDX_W-2){1'b0}}, idx_q, 2'b00};
        mgmt_data = hdr_word(cur_q.hdr, idx_q);
    end

    // Error pulse outputs: driven only in FIRE, zero otherwise.
    always_comb begin
        fire     = (ph_q == PH_FIRE);
        err_vec  = '0;
        err_func = '0;
        if (fire) begin
            err_vec  = {cur_q.log_hdr, cur_q.kind};
            err_func = cur_q.func;
        end
    end

    // Acknowledge tally since the last pop, kept for the ordering check.
    logic [IDX_W:0] ack_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                           ack_seen_q <= '0;
        else if (pop)                         ack_seen_q <= '0;
        else if (ph_q == PH_WAIT && mgmt_ack) ack_seen_q <= ack_seen_q + 1'b1;
    end

    // R3
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_wr |=> !mgmt_wr);
    // R6
    log_after_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_vec[KIND_W] |-> (ack_seen_q == (IDX_W+1)'(HDR_WORDS)));
    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_WAIT && !mgmt_ack) |=> (!mgmt_wr && $stable(mgmt_addr)));
    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (err_vec == '0 && err_func == '0));
    // R9
    nolog_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !req.log_hdr) |=> (fire && !mgmt_wr));
endmodule

// File: rtl/errhdr_seq.sv
// Top: error report header sequencer. Holds one request, writes the header through the
// management port when logging is asked for, then pulses the error vector with spacing.
// Assumes a single clock domain; crossing into the core's domain happens elsewhere.
module errhdr_seq
    import errhdr_pkg::*;
#(
    parameter int                GAP      = 8,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] HDR_BASE = 12'h81C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [KIND_W-1:0] req_kind,
    input  logic              req_log,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [HDR_W-1:0]  req_hdr,
    output logic              mgmt_wr,
    output logic [ADDR_W-1:0] mgmt_addr,
    output logic [WORD_W-1:0] mgmt_data,
    input  logic              mgmt_ack,
    output logic [KIND_W:0]   err_vec,
    output logic [FUNC_W-1:0] err_func
);
    localparam int SINCE_W = $clog2(GAP + 1);

    err_req_t in_req, held_req;
    logic     slot_full, pop, gap_open, fire;

    assign in_req = '{log_hdr: req_log, func: req_func, kind: req_kind, hdr: req_hdr};

    errhdr_slot u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (req_valid),
        .push_req   (in_req),
        .push_ready (req_ready),
        .pop        (pop),
        .full       (slot_full),
        .held_req   (held_req)
    );

    errhdr_gap #(.GAP(GAP)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .open  (gap_open)
    );

    errhdr_fsm #(.ADDR_W(ADDR_W), .HDR_BASE(HDR_BASE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .have_req  (slot_full),
        .gap_open  (gap_open),
        .req       (held_req),
        .mgmt_ack  (mgmt_ack),
        .pop       (pop),
        .mgmt_wr   (mgmt_wr),
        .mgmt_addr (mgmt_addr),
        .mgmt_data (mgmt_data),
        .err_vec   (err_vec),
        .err_func  (err_func),
        .fire      (fire)
    );

    // Independent spacing monitor: cycles since the last pulse, saturating at GAP.
    logic [SINCE_W-1:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                           since_q <= SINCE_W'(GAP);
        else if (err_vec != '0)               since_q <= SINCE_W'(1);
        else if (since_q < SINCE_W'(GAP))     since_q <= since_q + 1'b1;
    end

    // R8
    err_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vec != '0) |-> (since_q >= SINCE_W'(GAP)));
    // R2
    ready_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !pop) |=> !req_ready);
endmodule

// File: tb/tb_errhdr_seq.sv
module tb_errhdr_seq;
    localparam int GAP = 8;
    localparam int N   = 48;

    logic         clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [5:0]   req_kind = '0;
    logic         req_log = 1'b0;
    logic [2:0]   req_func = '0;
    logic [127:0] req_hdr = '0;
    logic         mgmt_ack = 1'b0;
    logic         req_ready, mgmt_wr;
    logic [11:0]  mgmt_addr;
    logic [31:0]  mgmt_data;
    logic [6:0]   err_vec;
    logic [2:0]   err_func;

    errhdr_seq #(.GAP(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_log(req_log), .req_func(req_func), .req_hdr(req_hdr),
        .mgmt_wr(mgmt_wr), .mgmt_addr(mgmt_addr), .mgmt_data(mgmt_data),
        .mgmt_ack(mgmt_ack), .err_vec(err_vec), .err_func(err_func)
    );

    int checks = 0, errors = 0, cyc = 0, sent = 0, hold = 0, ack_left = 0;
    int last_pulse = -100;
    logic [31:0] seed = 32'h1234_5678;

    bit           s_log [N];
    logic [5:0]   s_kind[N];
    logic [2:0]   s_func[N];
    logic [127:0] s_hdr [N];
    int           s_gap [N];

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Behavioural model: slot occupancy, pulse distance, and the request in flight.
    bit m_slot = 0, m_s_log, m_c_log;
    logic [5:0] m_s_kind, m_c_kind;
    logic [2:0] m_s_func, m_c_func;
    logic [127:0] m_s_hdr, m_c_hdr;
    int m_phase = 0;   // 0 idle, 1 strobe, 2 awaiting ack, 3 pulse
    int m_word = 0;
    int m_since = 1000;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_slot = 0; m_phase = 0; m_word = 0; m_since = 1000;
        end else begin
            bit take;
            int old_phase;
            take = req_valid && !m_slot;
            old_phase = m_phase;
            case (m_phase)
                0: if (m_slot && m_since >= GAP - 1) begin
                    m_c_log = m_s_log; m_c_kind = m_s_kind;
                    m_c_func = m_s_func; m_c_hdr = m_s_hdr;
                    m_slot = 0; m_word = 0;
                    m_phase = m_c_log ? 1 : 3;
                end
                1: m_phase = 2;
                2: if (mgmt_ack) begin
                    if (m_word == 3) m_phase = 3;
                    else begin m_word++; m_phase = 1; end
                end
                default: m_phase = 0;
            endcase
            if (old_phase == 3) m_since = 1;
            else if (m_since < 1000) m_since++;
            if (take) begin
                m_slot = 1; m_s_log = req_log; m_s_kind = req_kind;
                m_s_func = req_func; m_s_hdr = req_hdr;
            end
        end
    end

    // Compare every cycle, then drive the next inputs.
    always @(negedge clk) begin
        logic [6:0] exp_err;
        logic [2:0] exp_func;
        bit exp_wr;
        cyc++;
        if (rst_n) begin
            chk(req_ready == !m_slot, "R2", "req_ready", 128'(req_ready), 128'(!m_slot));
            exp_wr = (m_phase == 1);
            chk(mgmt_wr == exp_wr, (m_phase == 2) ? "R5" : (m_c_log ? "R3" : "R9"),
                "mgmt_wr", 128'(mgmt_wr), 128'(exp_wr));
            if (exp_wr) begin
                chk(mgmt_addr == 12'(12'h81C + 4 * m_word), "R3", "mgmt_addr",
                    128'(mgmt_addr), 128'(12'h81C + 4 * m_word));
                chk(mgmt_data == 32'(m_c_hdr >> (32 * (3 - m_word))), "R4", "mgmt_data",
                    128'(mgmt_data), 128'(32'(m_c_hdr >> (32 * (3 - m_word)))));
            end
            exp_err  = (m_phase == 3) ? {m_c_log, m_c_kind} : 7'd0;
            exp_func = (m_phase == 3) ? m_c_func : 3'd0;
            chk(err_vec == exp_err, exp_err[6] ? "R6" : "R7", "err_vec",
                128'(err_vec), 128'(exp_err));
            chk(err_func == exp_func, "R7", "err_func", 128'(err_func), 128'(exp_func));
            if (err_vec != 0) begin
                chk(cyc - last_pulse >= GAP, "R8", "pulse distance",
                    128'(cyc - last_pulse), 128'(GAP));
                last_pulse = cyc;
            end

            // Management port responder: ack 1 to 3 cycles after each strobe, stray acks otherwise.
            if (mgmt_wr) begin
                ack_left = 1 + int'(rnd() % 3);
                mgmt_ack = 1'b0;
            end else if (ack_left > 0) begin
                ack_left--;
                mgmt_ack = (ack_left == 0);
            end else begin
                mgmt_ack = (rnd() % 5 == 0);
            end

            // Request driver: junk is offered while not ready and must be ignored (R2).
            if (hold > 0) begin
                hold--;
                req_valid = 1'b0;
            end else if (sent < N) begin
                req_valid = 1'b1;
                if (req_ready) begin
                    req_log = s_log[sent]; req_kind = s_kind[sent];
                    req_func = s_func[sent]; req_hdr = s_hdr[sent];
                    hold = s_gap[sent];
                    sent++;
                end else begin
                    req_log = rnd() % 2 == 0; req_kind = 6'(rnd());
                    req_func = 3'(rnd()); req_hdr = {rnd(), rnd(), rnd(), rnd()};
                end
            end else begin
                req_valid = 1'b0;
            end
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            s_log[i]  = rnd() % 2 == 0;
            s_kind[i] = 6'(rnd());
            if (s_kind[i] == 0) s_kind[i] = 6'h01;
            s_func[i] = 3'(rnd());
            s_hdr[i]  = {rnd(), rnd(), rnd(), rnd()};
            s_gap[i]  = (rnd() % 6 == 0) ? 12 : int'(rnd() % 3);
        end
        // Directed opening: two unlogged back to back (R8, R9), then logged ones (R3, R6).
        s_log[0] = 0; s_kind[0] = 6'h21; s_func[0] = 3'd1; s_gap[0] = 0;
        s_log[1] = 0; s_kind[1] = 6'h02; s_func[1] = 3'd6; s_gap[1] = 0;
        s_log[2] = 1; s_kind[2] = 6'h3C; s_func[2] = 3'd7; s_gap[2] = 0;
        s_hdr[2] = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        s_log[3] = 1; s_kind[3] = 6'h04; s_func[3] = 3'd0; s_gap[3] = 20;
        s_log[4] = 0; s_kind[4] = 6'h10; s_func[4] = 3'd3; s_gap[4] = 20;

        repeat (3) @(negedge clk);
        // R1: state seen at the ports while held in reset
        chk(err_vec == 0, "R1", "err_vec in reset", 128'(err_vec), 0);
        chk(err_func == 0, "R1", "err_func in reset", 128'(err_func), 0);
        chk(mgmt_wr == 0, "R1", "mgmt_wr in reset", 128'(mgmt_wr), 0);
        chk(req_ready == 1, "R1", "req_ready in reset", 128'(req_ready), 1);
        @(posedge clk);
        #2 rst_n = 1'b1;
        wait (sent == N && m_phase == 0 && !m_slot);
        repeat (30) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=%0d sent expected=%0d", sent, N);
        finish_run();
    end
endmodule